// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers every reset request in the chip and turns them into three domain reset outputs. The requests are the power-on input, the supply-good status, an external reset pin and eight internal or debug requests. Each request belongs to a class. The power class covers power-on and loss of supply. The hard class resets every domain. The soft class resets the core and peripheral domains but leaves the debug domain running. When requests of more than one class are active in the same cycle, the strongest class wins.

Each output goes low asynchronously as soon as a request of a class that covers it appears. After every such request has gone away, the reset is stretched for a fixed number of controller clock cycles. It is then released through a two-flop synchronizer clocked by the destination domain clock.

A cause register keeps one sticky flag per request. Software can read the flags and pick a separate start-up path for each cause, then clear them with a write-1-to-clear strobe. The flags are cleared only by power-on, so a hard or soft reset leaves the record of earlier causes in place.

Top module: `rstc_top`

## Requirements
- R1: While any hard-class or soft-class request is active, `core_rst_no` and `periph_rst_no` are low, including between clock edges: assertion does not wait for a clock.
- R2: The last request of a class goes inactive between edges. The outputs that class covers then rise on the (HOLD_CYC+2)-th rising edge after that point: HOLD_CYC stretch cycles, then two synchronizer flops. With the defaults that is edge 18.
- R3: Each active request sets its own flag in `cause_o` at the next controller clock edge. Bit 0 is power-on. Bit 1 is supply loss. Bit k+2 is `src_i[k]`. Several requests in one cycle set all of their bits.
- R4: The hard class is power-on, supply loss and `src_i[5:0]` (0 pin, 1 PLL unlock, 2 watchdog, 3 error shutdown, 4 debug hard, 5 JTAG). It drives all three outputs low. The soft class is `src_i[8:6]` (6 external software, 7 debug soft, 8 JTAG soft). It drives only the core and peripheral outputs low, and `dbg_rst_no` is unaffected.
- R5: While `pwr_good_i` is low, all three outputs are held low. A drop during normal operation starts a new reset.
- R6: When requests of several classes are active together, the strongest class applies (power, then hard, then soft). A hard request together with a soft one also resets the debug domain.
- R7: Flags are sticky. With `clr_we_i` high, each 1 in `clr_mask_i` clears the matching flag at the next edge. A flag whose request is still active in that cycle stays set.
- R8: Power-on (`rst_ni` low) clears all flags and sets only bit 0. Hard and soft resets leave earlier flags untouched.
- R9: During and right after power-on, `cause_o` equals 1 and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, also the debug domain clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| core_clk_i | input | 1 | Core domain clock |
| periph_clk_i | input | 1 | Peripheral domain clock |
| pwr_good_i | input | 1 | Supply good status, low means supply lost |
| src_i | input | 9 | Reset requests, active high, bit map as in R4 |
| clr_we_i | input | 1 | Write strobe for clearing flags |
| clr_mask_i | input | 11 | Write-1-to-clear mask for the flags |
| cause_o | output | 11 | Sticky reset cause flags, bit map as in R3 |
| core_rst_no | output | 1 | Core domain reset, active low |
| periph_rst_no | output | 1 | Peripheral domain reset, active low |
| dbg_rst_no | output | 1 | Debug domain reset, active low |

## Verification
The hardest case to reach from the ports is a new request that arrives while an earlier one is still being stretched or synchronized. The release must then restart from the newer request, and a clear that lands in the same cycle as a set must lose. Directed steps cover the single-source, mixed-class, supply-drop and mid-run power-on cases. The stimulus also drives sparse random request masks, supply dips and random clear writes for several thousand cycles, so that requests and clears fall inside each other's hold windows. Every cycle is compared against a bench model that counts quiet edges per class.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC  = 9;
  localparam int NFLAG = NSRC + 2;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SOFT  = 2'd1,
    CLS_HARD  = 2'd2,
    CLS_POWER = 2'd3
  } rst_cls_e;
endpackage

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic req_i,
  output logic held_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          held_q;

  // request asserts hold at once; count starts only once it is gone
  always_ff @(posedge clk_i or posedge req_i) begin
    if (req_i) begin
      cnt_q  <= '0;
      held_q <= 1'b1;
    end else if (held_q) begin
      if (cnt_q == CW'(HOLD_CYC - 1)) held_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic req_i,
  output logic rst_no
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or posedge req_i) begin
    if (req_i) ff_q <= '0;
    else       ff_q <= {ff_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = ff_q[STAGES-1];
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause #(
  parameter int NFLAG = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  output logic [NFLAG-1:0] flags_o
);
  localparam logic [NFLAG-1:0] POR_VAL = NFLAG'(1);

  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= POR_VAL;
    else         flags_q <= (flags_q & ~clr_eff) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int              HOLD_CYC  = 16,
  parameter int              SYNC_STG  = 2,
  parameter logic [NSRC-1:0] SOFT_MASK = 9'b1_1100_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_clk_i,
  input  logic             periph_clk_i,
  input  logic             pwr_good_i,
  input  logic [NSRC-1:0]  src_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  output logic [NFLAG-1:0] cause_o,
  output logic             core_rst_no,
  output logic             periph_rst_no,
  output logic             dbg_rst_no
);
  localparam int NLVL = 2;  // level 0: soft and above, level 1: hard and above
  localparam int NDOM = 3;  // 0 core, 1 periph, 2 debug

  rst_cls_e        cls;
  logic            hard_any;
  logic            soft_any;
  logic [NLVL-1:0] lvl_req;
  logic [NLVL-1:0] lvl_held;
  logic [NDOM-1:0] dom_clk;
  logic [NDOM-1:0] dom_req;
  logic [NDOM-1:0] dom_rst_n;

  assign hard_any = |(src_i & ~SOFT_MASK);
  assign soft_any = |(src_i & SOFT_MASK);

  // strongest class wins
  always_comb begin
    if (!rst_ni || !pwr_good_i) cls = CLS_POWER;
    else if (hard_any)          cls = CLS_HARD;
    else if (soft_any)          cls = CLS_SOFT;
    else                        cls = CLS_NONE;
  end

  assign lvl_req[0] = (cls >= CLS_SOFT);
  assign lvl_req[1] = (cls >= CLS_HARD);

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    rstc_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
      .clk_i  (clk_i),
      .req_i  (lvl_req[l]),
      .held_o (lvl_held[l])
    );
  end

  assign dom_clk = {clk_i, periph_clk_i, core_clk_i};
  assign dom_req = {lvl_held[1], lvl_held[0], lvl_held[0]};

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    rstc_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i  (dom_clk[d]),
      .req_i  (dom_req[d]),
      .rst_no (dom_rst_n[d])
    );
  end

  assign core_rst_no   = dom_rst_n[0];
  assign periph_rst_no = dom_rst_n[1];
  assign dbg_rst_no    = dom_rst_n[2];

  rstc_cause #(.NFLAG(NFLAG)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      ({src_i, ~pwr_good_i, 1'b0}),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .flags_o    (cause_o)
  );
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk
  import rstc_pkg::*;
#(
  parameter logic [NSRC-1:0] SOFT_MASK = 9'b1_1100_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_good_i,
  input logic [NSRC-1:0]  src_i,
  input logic             clr_we_i,
  input logic [NFLAG-1:0] cause_o,
  input logic             core_rst_no,
  input logic             periph_rst_no,
  input logic             dbg_rst_no
);
  logic hard_any, soft_any;
  assign hard_any = !pwr_good_i || |(src_i & ~SOFT_MASK);
  assign soft_any = |(src_i & SOFT_MASK);

  AST_REQ_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_any || soft_any) |-> (!core_rst_no && !periph_rst_no)); // R1
  AST_SUPPLY_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (!core_rst_no && !periph_rst_no && !dbg_rst_no)); // R5
  AST_DBG_HARD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dbg_rst_no) |-> (hard_any || $past(hard_any))); // R4
  AST_DBG_QUIET_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_rst_no) |-> (!hard_any && $past(!hard_any) && $past(!hard_any, 2))); // R2
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((cause_o[NFLAG-1:2] & $past(src_i)) == $past(src_i))); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R7
endmodule

bind rstc_top rstc_chk #(.SOFT_MASK(SOFT_MASK)) u_rstc_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_good_i    (pwr_good_i),
  .src_i         (src_i),
  .clr_we_i      (clr_we_i),
  .cause_o       (cause_o),
  .core_rst_no   (core_rst_no),
  .periph_rst_no (periph_rst_no),
  .dbg_rst_no    (dbg_rst_no)
);

// File: tb/rstc_top_tb_top.sv
`timescale 1ns/1ps
module rstc_top_tb_top;
  localparam int HOLD = 16;
  localparam int NS   = 9;
  localparam int NF   = 11;
  localparam logic [NS-1:0] SOFTM = 9'b1_1100_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pg = 1'b1;
  logic [NS-1:0] src = '0;
  logic          we = 1'b0;
  logic [NF-1:0] mask = '0;
  logic [NF-1:0] cause;
  logic          core_n, per_n, dbg_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // model state
  logic [NF-1:0] m_flags = NF'(1);
  int            q_hard = 0;
  int            q_any  = 0;
  logic          p_rst_n = 1'b0, p_pg = 1'b1, p_we = 1'b0;
  logic [NS-1:0] p_src = '0;
  logic [NF-1:0] p_mask = '0;

  always #10 clk = ~clk;

  rstc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .core_clk_i(clk), .periph_clk_i(clk),
    .pwr_good_i(pg), .src_i(src), .clr_we_i(we), .clr_mask_i(mask),
    .cause_o(cause), .core_rst_no(core_n), .periph_rst_no(per_n), .dbg_rst_no(dbg_n)
  );

  function automatic bit is_hard(logic r, logic g, logic [NS-1:0] s);
    return !r || !g || |(s & ~SOFTM);
  endfunction

  function automatic bit is_soft(logic [NS-1:0] s);
    return |(s & SOFTM);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: update model for the edge just passed, drive, compare
  task automatic step(logic r, logic g, logic [NS-1:0] s, logic w, logic [NF-1:0] m);
    bit e_dbg, e_core;
    string tag;
    @(negedge clk);
    if (p_rst_n) m_flags = (m_flags & ~(p_we ? p_mask : '0)) | {p_src, ~p_pg, 1'b0};
    else         m_flags = NF'(1);
    if (is_hard(p_rst_n, p_pg, p_src)) q_hard = 0; else q_hard++;
    if (is_hard(p_rst_n, p_pg, p_src) || is_soft(p_src)) q_any = 0; else q_any++;
    rst_n = r; pg = g; src = s; we = w; mask = m;
    if (!r) m_flags = NF'(1);
    if (is_hard(r, g, s)) q_hard = 0;
    if (is_hard(r, g, s) || is_soft(s)) q_any = 0;
    p_rst_n = r; p_pg = g; p_src = s; p_we = w; p_mask = m;
    #1;
    e_dbg  = (q_hard >= HOLD + 2);
    e_core = (q_any  >= HOLD + 2);
    if (!g) tag = "R5";
    else if (is_hard(r, g, s) || is_soft(s)) tag = "R1";
    else tag = "R2";
    chk(core_n == e_core, {tag, " core"}, core_n, e_core);
    chk(per_n  == e_core, {tag, " periph"}, per_n, e_core);
    chk(dbg_n  == e_dbg, (is_soft(s) && !is_hard(r, g, s)) ? "R4 dbg" : {tag, " dbg"}, dbg_n, e_dbg);
    chk(cause == m_flags, "R3/R7/R8 cause", cause, m_flags);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0, 1'b0, '0);
  endtask

  initial begin
    // R9: reset state
    step(1'b0, 1'b1, '0, 1'b0, '0);
    step(1'b0, 1'b1, '0, 1'b0, '0);
    chk(cause == NF'(1), "R9 por flags", cause, 1);
    chk(!core_n && !per_n && !dbg_n, "R9 outputs low", {core_n, per_n, dbg_n}, 0);
    idle(HOLD + 4);
    chk(core_n && dbg_n, "R2 released", {core_n, dbg_n}, 3);
    // watchdog: hard class, R4 / R3 / R8
    step(1'b1, 1'b1, 9'h004, 1'b0, '0);
    idle(HOLD + 4);
    chk(cause == 11'h011, "R8 flags kept", cause, 11'h011);
    // debug soft: debug domain untouched, R4
    step(1'b1, 1'b1, 9'h080, 1'b0, '0);
    chk(dbg_n == 1'b1, "R4 soft spares dbg", dbg_n, 1);
    idle(HOLD + 4);
    // R7: clear loses to active set, then clear works
    step(1'b1, 1'b1, 9'h004, 1'b1, 11'h010);
    step(1'b1, 1'b1, '0, 1'b1, 11'h211);
    step(1'b1, 1'b1, '0, 1'b0, '0);
    chk(cause == 11'h000, "R7 cleared", cause, 0);
    idle(HOLD + 4);
    // R6: PLL unlock with JTAG soft in the same cycle
    step(1'b1, 1'b1, 9'h102, 1'b0, '0);
    chk(dbg_n == 1'b0, "R6 strongest class", dbg_n, 0);
    idle(HOLD + 4);
    // R5: supply dip
    step(1'b1, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    idle(HOLD + 4);
    // overlap: soft request while hard hold in progress
    step(1'b1, 1'b1, 9'h001, 1'b0, '0);
    idle(5);
    step(1'b1, 1'b1, 9'h040, 1'b0, '0);
    idle(HOLD + 4);
    // R8: power-on mid-run wipes flags
    step(1'b0, 1'b1, 9'h1FF, 1'b0, '0);
    step(1'b1, 1'b1, '0, 1'b0, '0);
    chk(cause == NF'(1), "R8 por clears", cause, 1);
    idle(HOLD + 4);
    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [NS-1:0] s;
      logic g, w;
      logic [NF-1:0] m;
      s = ($urandom % 25 == 0) ? NS'($urandom) : '0;
      g = ($urandom % 70 != 0);
      w = ($urandom % 8 == 0);
      m = NF'($urandom);
      step(1'b1, g, s, w, m);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule